// File: doc/BRIEF.md
# Key-Protected Vector Table Base Register

This block holds the 24-bit start address of the interrupt vector table and drives it, assembled, to the interrupt fetch logic. Software sees the address as two 16-bit registers on a simple synchronous bus slave. The upper of the two holds address bits 23:16. The lower holds bits 15:8. Bits 7:0 are tied to zero, so the table always starts on a 256-byte boundary.

Software cannot move the table by accident. A base register write lands only while a separate 16-bit key register holds 0x0096. The key stays in force until software writes any other value to the key register. A read-only mirror region returns the current base so that other agents can find the table.

Every read has one cycle of latency. The value returned reflects register state from before any write in the same cycle.

Top module: `vtab_base_guard`

## Requirements
- R1: After reset the base output `vecBase` is 0x008000 and the key register reads 0x0000, so the base registers start locked.
- R2: The key register at address 0x5324 is a full 16-bit read/write register; a read returns the last 16-bit value written.
- R3: While the key register holds any value other than 0x0096, writes to 0x5328 and 0x532a leave `vecBase` unchanged.
- R4: While the key register holds 0x0096, a write to 0x5328 loads write-data bits 15:8 into base bits 15:8, and a write to 0x532a loads write-data bits 7:0 into base bits 23:16.
- R5: Base bits 7:0 are always zero. Reads of 0x5328 return base bits 15:8 in bits 15:8 and zero in bits 7:0. Reads of 0x532a return base bits 23:16 in bits 7:0 and zero in bits 15:8.
- R6: Unlock survives base register writes, and writing any value other than 0x0096 to the key register relocks at once.
- R7: A read of 0xffff80 returns base bits 15:0 and a read of 0xffff82 returns base bits 23:16 zero-extended; writes there have no effect.
- R8: A read of any other address returns 0x0000, and a write to any other address changes neither `vecBase` nor the key.
- R9: `rdData` presents the result of a read in the cycle after `rdEn` is high and is 0x0000 in any cycle that follows one without `rdEn`.
- R10: An accepted write shows on `vecBase` directly after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 24 | Byte address of the access |
| wrEn | input | 1 | Write strobe for this cycle |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe for this cycle |
| rdData | output | 16 | Read data, valid the cycle after rdEn |
| vecBase | output | 24 | Assembled vector table base address |

## Verification
The hardest state to reach from the ports is a key value that is close to the unlock value but not equal to it. One such value is 0x0095, which differs from the key only in its low bits. Another is 0x0196, which differs only in its upper byte. A base write after either value must be rejected. The stimulus writes each of these values, then attempts base writes and reads the key and `vecBase` back. It also keeps the key unlocked across several base writes before relocking, so that a design that drops the unlock after one write, or that compares only one byte of the key, produces a wrong `vecBase`.

// File: rtl/vtab_base_pkg.sv
package vtab_base_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_KEY,
    RD_LO,
    RD_HI,
    RD_MIRLO,
    RD_MIRHI
  } rdSel_e;

  typedef struct packed {
    logic   loadKey;
    logic   loadMid;
    logic   loadHigh;
    logic   readGo;
    rdSel_e readSel;
  } ctrlStrb_t;

endpackage

// File: rtl/vtab_base_ctrl.sv
module vtab_base_ctrl
  import vtab_base_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter logic [23:0] KEY_ADDR  = 24'h005324,
  parameter logic [23:0] LO_ADDR   = 24'h005328,
  parameter logic [23:0] HI_ADDR   = 24'h00532a,
  parameter logic [23:0] MIR_ADDR  = 24'hffff80
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              keyOpen,
  output ctrlStrb_t         strb
);

  localparam logic [ADDR_W-1:0] MIR_HI_ADDR = ADDR_W'(MIR_ADDR + 24'd2);

  logic hitKey, hitLo, hitHi, hitMirLo, hitMirHi;

  always_comb begin
    hitKey   = (busAddr == ADDR_W'(KEY_ADDR));
    hitLo    = (busAddr == ADDR_W'(LO_ADDR));
    hitHi    = (busAddr == ADDR_W'(HI_ADDR));
    hitMirLo = (busAddr == ADDR_W'(MIR_ADDR));
    hitMirHi = (busAddr == MIR_HI_ADDR);
  end

  always_comb begin
    strb          = '0;
    strb.loadKey  = wrEn && hitKey;
    strb.loadMid  = wrEn && hitLo && keyOpen;
    strb.loadHigh = wrEn && hitHi && keyOpen;
    strb.readGo   = rdEn;
    if (!rdEn)         strb.readSel = RD_NONE;
    else if (hitKey)   strb.readSel = RD_KEY;
    else if (hitLo)    strb.readSel = RD_LO;
    else if (hitHi)    strb.readSel = RD_HI;
    else if (hitMirLo) strb.readSel = RD_MIRLO;
    else if (hitMirHi) strb.readSel = RD_MIRHI;
    else               strb.readSel = RD_NONE;
  end

endmodule

// File: rtl/vtab_base_dpath.sv
module vtab_base_dpath
  import vtab_base_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter logic [15:0] KEY_VALUE = 16'h0096,
  parameter logic [7:0]  MID_RESET = 8'h80,
  parameter logic [7:0]  HI_RESET  = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              keyOpen,
  output logic [DATA_W-1:0] rdData,
  output logic [23:0]       vecBase
);

  localparam int BYTE_W = 8;
  localparam int PAD_W  = DATA_W - BYTE_W;

  logic [DATA_W-1:0] keyReg;
  logic [BYTE_W-1:0] midByte;
  logic [BYTE_W-1:0] highByte;
  logic [DATA_W-1:0] loWord;
  logic [DATA_W-1:0] hiWord;
  logic [DATA_W-1:0] readMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg   <= '0;
      midByte  <= MID_RESET;
      highByte <= HI_RESET;
    end else begin
      if (strb.loadKey)  keyReg   <= wrData;
      if (strb.loadMid)  midByte  <= wrData[DATA_W-1:PAD_W];
      if (strb.loadHigh) highByte <= wrData[BYTE_W-1:0];
    end
  end

  assign keyOpen = (keyReg == DATA_W'(KEY_VALUE));
  assign loWord  = {midByte, {BYTE_W{1'b0}}};
  assign hiWord  = {{PAD_W{1'b0}}, highByte};
  assign vecBase = {highByte, midByte, {BYTE_W{1'b0}}};

  always_comb begin
    unique case (strb.readSel)
      RD_KEY:   readMux = keyReg;
      RD_LO:    readMux = loWord;
      RD_HI:    readMux = hiWord;
      RD_MIRLO: readMux = loWord;
      RD_MIRHI: readMux = hiWord;
      default:  readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strb.readGo) rdData <= readMux;
    else                  rdData <= '0;
  end

endmodule

// File: rtl/vtab_base_guard.sv
module vtab_base_guard
  import vtab_base_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] KEY_VALUE = 16'h0096,
  parameter logic [23:0] KEY_ADDR  = 24'h005324,
  parameter logic [23:0] LO_ADDR   = 24'h005328,
  parameter logic [23:0] HI_ADDR   = 24'h00532a,
  parameter logic [23:0] MIR_ADDR  = 24'hffff80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [23:0]       vecBase
);

  ctrlStrb_t strb;
  logic      keyOpen;

  vtab_base_ctrl #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR), .MIR_ADDR(MIR_ADDR)
  ) u_ctrl (
    .busAddr(busAddr), .wrEn(wrEn), .rdEn(rdEn),
    .keyOpen(keyOpen), .strb(strb)
  );

  vtab_base_dpath #(
    .DATA_W(DATA_W), .KEY_VALUE(KEY_VALUE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .keyOpen(keyOpen), .rdData(rdData), .vecBase(vecBase)
  );

endmodule

// File: rtl/vtab_base_guard_chk.sv
module vtab_base_guard_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic [23:0]       vecBase
);

  logic [15:0] keyModel;
  logic        keyOk;
  logic        baseWrite;

  always_ff @(posedge clk) begin
    if (!rstN) keyModel <= '0;
    else if (wrEn && busAddr == ADDR_W'(24'h005324)) keyModel <= wrData;
  end

  assign keyOk     = (keyModel == 16'h0096);
  assign baseWrite = wrEn && keyOk &&
                     (busAddr == ADDR_W'(24'h005328) || busAddr == ADDR_W'(24'h00532a));

  // R5: table start always on a 256-byte boundary
  p_low_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    vecBase[7:0] == 8'h00);

  // R3, R8: base moves only on an accepted base write
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !baseWrite |=> $stable(vecBase));

  // R4, R10: accepted low write lands on the next edge
  p_mid_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (baseWrite && busAddr == ADDR_W'(24'h005328)) |=> vecBase[15:8] == $past(wrData[15:8]));

  // R4: accepted high write lands on the next edge
  p_high_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (baseWrite && busAddr == ADDR_W'(24'h00532a)) |=> vecBase[23:16] == $past(wrData[7:0]));

  // R9: idle cycle yields zero read data
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> rdData == '0);

  // R7: mirror low word tracks the base
  p_mirror_lo_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busAddr == ADDR_W'(24'hffff80)) |=> rdData == $past(vecBase[15:0]));

endmodule

bind vtab_base_guard vtab_base_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
  .rdEn(rdEn), .rdData(rdData), .vecBase(vecBase)
);

// File: tb/vtab_base_guard_test.sv
module vtab_base_guard_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] busAddr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic [23:0] vecBase;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t scq[$];

  always #2.5 clk = ~clk;

  vtab_base_guard uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .vecBase(vecBase)
  );

  task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkBase(input logic [23:0] exp, input string tag);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    total++;
    if (vecBase !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, vecBase, exp);
    end
  endtask

  task automatic busWrite(input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
  endtask

  task automatic busRead(input logic [23:0] a, input logic [15:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    busAddr = a; wrEn = 1'b0; rdEn = 1'b1;
    it.exp = exp; it.tag = tag;
    scq.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  // monitor: pop one expected item for every read captured at an edge
  initial begin
    forever begin
      logic tookRead;
      @(posedge clk);
      tookRead = rdEn && rstN;
      #1;
      if (tookRead) begin
        if (scq.size() == 0) begin
          total++; bad++;
          $display("FAIL R9: actual=unexpected read expected=none");
        end else begin
          item_t it;
          it = scq.pop_front();
          check16(rdData, it.exp, it.tag);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    checkBase(24'h008000, "R1 reset base");
    busRead(24'h005324, 16'h0000, "R1 key after reset");
    busRead(24'h005328, 16'h8000, "R1 low reg after reset");
    busRead(24'h00532a, 16'h0000, "R1 high reg after reset");
    idle();
    @(negedge clk);
    check16(rdData, 16'h0000, "R9 idle read data");

    // locked writes
    busWrite(24'h005328, 16'h12ff);
    busWrite(24'h00532a, 16'h0034);
    checkBase(24'h008000, "R3 locked writes ignored");
    busRead(24'h005328, 16'h8000, "R3 low reg unchanged");

    // near-miss key
    busWrite(24'h005324, 16'h0095);
    busWrite(24'h005328, 16'h1200);
    checkBase(24'h008000, "R3 near key 0095 rejects");
    busRead(24'h005324, 16'h0095, "R2 key readback");

    // unlock
    busWrite(24'h005324, 16'h0096);
    busWrite(24'h005328, 16'h12ab);
    checkBase(24'h001200, "R4 R10 low write accepted");
    busRead(24'h005328, 16'h1200, "R5 low byte reads zero");
    busWrite(24'h00532a, 16'hcd34);
    checkBase(24'h341200, "R4 high write accepted");
    busRead(24'h00532a, 16'h0034, "R5 high reserved bits zero");
    busRead(24'hffff80, 16'h1200, "R7 mirror low");
    busRead(24'hffff82, 16'h0034, "R7 mirror high");

    // unlock persists
    busWrite(24'h005328, 16'h56ff);
    checkBase(24'h345600, "R6 unlock persists");

    // mirror and undecoded writes
    busWrite(24'hffff80, 16'hffff);
    busWrite(24'hffff82, 16'hffff);
    busWrite(24'h005326, 16'hffff);
    checkBase(24'h345600, "R7 R8 stray writes ignored");
    busRead(24'h005324, 16'h0096, "R8 key untouched by stray write");
    busRead(24'h005326, 16'h0000, "R8 undecoded read");
    busRead(24'hffff84, 16'h0000, "R8 undecoded read past mirror");

    // relock with upper-byte near miss
    busWrite(24'h005324, 16'h0196);
    busWrite(24'h00532a, 16'h00ff);
    busWrite(24'h005328, 16'hff00);
    checkBase(24'h345600, "R6 relock blocks writes");
    busRead(24'h005324, 16'h0196, "R2 key full width");
    idle();
    @(negedge clk);
    check16(rdData, 16'h0000, "R9 idle after read");

    // reset again
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    checkBase(24'h008000, "R1 base after second reset");
    busRead(24'h005324, 16'h0000, "R1 key after second reset");
    idle();
    idle();

    total++;
    if (scq.size() != 0) begin
      bad++;
      $display("FAIL R9: actual=%0d pending expected=0 pending", scq.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule